// File: doc/BRIEF.md
# DMA Request-to-Channel Mapper

This block sits between the peripheral request lines of a chip and a bank of DMA channels. Each of the request inputs owns a small map register that says whether the request is in use and which channel it drives. The block brings the raw request lines into its own clock domain, merges every validly mapped request onto its channel, and presents the merged level to the channel's flow-control logic.

The block also tells the channel status logic when a channel's request level changes. A rising channel level produces a one-cycle "request after stop" set pulse. A falling level produces an "end of receive" set pulse and, in the same cycle, a clear pulse for the request-after-stop flag. The map table is reached through a simple register port. Requests below 64 decode in a low window, the rest decode in a separate high window, and three request-status words read as zero. Programming a valid mapping to a channel that is not built raises a sticky error.

Top module: `dma_req_mapper`

## Requirements
- R1: A map register for request n with n in 0..63 is written and read at byte address 0x100 + 4n. A read returns the 8 stored bits in bits 7:0 and zero above them. Bit 7 is the valid flag and bits 4:0 are the channel number.
- R2: Map registers for requests 64 up to NUM_REQ-1 sit at 0x1100 + 4(n-64). Addresses outside both windows, such as 0x200, read as zero and store nothing.
- R3: Addresses 0xE0, 0xE4 and 0xE8 always read zero. A write to them changes no map register.
- R4: A request whose map register has bit 7 clear, or whose channel number is NUM_CH or more, has no effect on any channel output.
- R5: `chan_active[c]` is the OR of every request mapped validly to channel c. It follows a request change that is set up before clock edge k after edge k+2, because of two synchroniser stages and one output register.
- R6: On the cycle where `chan_active[c]` rises, `ras_set[c]` is high for exactly that one cycle.
- R7: On the cycle where `chan_active[c]` falls, `eor_set[c]` and `ras_clr[c]` are both high for exactly that one cycle.
- R8: While a channel is already active, another request mapped to it that rises or falls produces no event and keeps the channel active.
- R9: A write that stores a value with bit 7 set and bits 4:0 of NUM_CH or more sets `map_err`. The flag stays set until reset. Writes that are in range, or that have bit 7 clear, leave it alone.
- R10: After reset every map register reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 16 | Byte address of the register port |
| reg_wdata | input | 32 | Write data; only bits 7:0 are stored |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| req_in | input | NUM_REQ | Raw peripheral request lines, asynchronous |
| chan_active | output | NUM_CH | Merged, synchronised request level per channel |
| ras_set | output | NUM_CH | One-cycle pulse on a channel's request rise |
| ras_clr | output | NUM_CH | One-cycle pulse on a channel's request fall |
| eor_set | output | NUM_CH | One-cycle end-of-receive pulse on a request fall |
| map_err | output | 1 | Sticky out-of-range mapping error |

## Verification
The bench goes after the address decode seam around the two windows. A decoder that aliased the high window onto the low one would overwrite request 6 when request 70 is written, and one that decoded 0x200 would report storage where there is none. Overlapping requests on one channel are driven to expose a design that edge-detects each request line on its own: such a design emits stray rise and fall pulses while the channel stays busy. Requests with bit 7 clear and requests mapped to a channel that is not built are toggled, because a router that skipped the valid or range check would drive a channel from them. A pseudo-random phase also checks the three-edge latency, since an extra or a missing stage shifts every output by one cycle against the reference model.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

  // Address layout of the register port (byte addresses).
  localparam int LO_BASE    = 32'h0100;
  localparam int LO_SLOTS   = 64;
  localparam int HI_BASE    = 32'h1100;
  localparam int STAT_BASE  = 32'h00E0;
  localparam int STAT_WORDS = 3;

  // Fields of one map entry.
  localparam int VALID_BIT = 7;
  localparam int CH_W      = 5;

  typedef struct packed {
    logic       hit;
    logic [7:0] idx;
  } map_sel_t;

  // Translate a byte address to a map table slot, across both windows.
  function automatic map_sel_t map_decode(input logic [15:0] addr, input int num_req);
    map_sel_t s;
    int a;
    int off;
    s = '0;
    a = int'(addr);
    if (addr[1:0] == 2'b00) begin
      if (a >= LO_BASE && a < LO_BASE + 4 * LO_SLOTS) begin
        off = (a - LO_BASE) / 4;
        if (off < num_req) begin
          s.hit = 1'b1;
          s.idx = 8'(off);
        end
      end else if (a >= HI_BASE && a < HI_BASE + 4 * (num_req - LO_SLOTS)) begin
        off = LO_SLOTS + (a - HI_BASE) / 4;
        s.hit = 1'b1;
        s.idx = 8'(off);
      end
    end
    return s;
  endfunction

  // True for the request-status words that read as zero.
  function automatic logic is_status(input logic [15:0] addr);
    int a;
    a = int'(addr);
    return (addr[1:0] == 2'b00) && (a >= STAT_BASE) && (a < STAT_BASE + 4 * STAT_WORDS);
  endfunction

  // A valid entry naming a channel that is not built.
  function automatic logic map_bad(input logic [7:0] v, input int num_ch);
    return v[VALID_BIT] && (int'(v[CH_W-1:0]) >= num_ch);
  endfunction

  // Does entry v route a request to channel ch?
  function automatic logic map_routes(input logic [7:0] v, input int ch);
    return v[VALID_BIT] && (int'(v[CH_W-1:0]) == ch);
  endfunction

endpackage

// File: rtl/dmx_sync.sv
module dmx_sync #(
  parameter int W = 75
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/dmx_map_regs.sv
module dmx_map_regs
  import dmx_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [15:0]            addr_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  output logic [NUM_REQ*8-1:0]   map_flat_o,
  output logic                   err_o
);
  logic [7:0] map_q [NUM_REQ];
  map_sel_t   sel;
  logic       wr_hit;
  logic       wr_bad;
  logic       err_q;
  logic       unused_wdata_hi;

  assign sel             = map_decode(addr_i, NUM_REQ);
  assign wr_hit          = we_i && sel.hit;
  assign wr_bad          = wr_hit && map_bad(wdata_i[7:0], NUM_CH);
  assign unused_wdata_hi = ^wdata_i[31:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REQ; r++) map_q[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REQ; r++) begin
        if (wr_hit && sel.idx == 8'(r)) map_q[r] <= wdata_i[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (wr_bad) err_q <= 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      if (sel.hit && sel.idx == 8'(r)) rdata_o = {24'b0, map_q[r]};
    end
  end

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_flat
    assign map_flat_o[r*8 +: 8] = map_q[r];
  end

  assign err_o = err_q;

  // R3: status words never return data
  a_r3_status_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    is_status(addr_i) |-> (rdata_o == 32'b0));

  // R9: the error flag never drops once raised
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R9: a bad write is always reported on the next cycle
  a_r9_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> err_o);
endmodule

// File: rtl/dmx_route.sv
module dmx_route
  import dmx_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_REQ-1:0]   req_s_i,
  input  logic [NUM_REQ*8-1:0] map_flat_i,
  output logic [NUM_CH-1:0]    act_o,
  output logic [NUM_CH-1:0]    rise_o,
  output logic [NUM_CH-1:0]    fall_o
);
  logic [NUM_CH-1:0] lvl;
  logic [NUM_CH-1:0] act_q;
  logic [NUM_CH-1:0] rise_q;
  logic [NUM_CH-1:0] fall_q;

  // Merge every validly mapped request onto its channel.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      lvl[c] = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        if (map_routes(map_flat_i[r*8 +: 8], c) && req_s_i[r]) lvl[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      act_q  <= lvl;
      rise_q <= lvl & ~act_q;
      fall_q <= act_q & ~lvl;
    end
  end

  assign act_o  = act_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  // R6: a rise pulse only where the level just went high
  a_r6_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_q & ~(act_q & ~$past(act_q))) == '0));

  // R7: a fall pulse only where the level just went low
  a_r7_fall_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall_q & ~($past(act_q) & ~act_q)) == '0));

  // R5: every level change is announced by exactly one event
  a_r5_change_signalled: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_q | fall_q) == (act_q ^ $past(act_q))));

  // R7: a channel cannot rise and fall in the same cycle
  a_r7_no_double_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_q & fall_q) == '0));
endmodule

// File: rtl/dma_req_mapper.sv
module dma_req_mapper #(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [15:0]        reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_REQ-1:0] req_in,
  output logic [NUM_CH-1:0]  chan_active,
  output logic [NUM_CH-1:0]  ras_set,
  output logic [NUM_CH-1:0]  ras_clr,
  output logic [NUM_CH-1:0]  eor_set,
  output logic               map_err
);
  localparam int MAP_BITS = NUM_REQ * 8;

  logic [NUM_REQ-1:0]  req_sync;
  logic [MAP_BITS-1:0] map_flat;
  logic [NUM_CH-1:0]   ch_rise;
  logic [NUM_CH-1:0]   ch_fall;

  dmx_sync #(.W(NUM_REQ)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (req_in),
    .q_o   (req_sync)
  );

  dmx_map_regs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (reg_we),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .rdata_o    (reg_rdata),
    .map_flat_o (map_flat),
    .err_o      (map_err)
  );

  dmx_route #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_s_i    (req_sync),
    .map_flat_i (map_flat),
    .act_o      (chan_active),
    .rise_o     (ch_rise),
    .fall_o     (ch_fall)
  );

  assign ras_set = ch_rise;
  assign ras_clr = ch_fall;
  assign eor_set = ch_fall;

  // R7: end-of-receive and the request-after-stop clear travel together
  a_r7_pulses_paired: assert property (@(posedge clk) disable iff (!rst_n)
    (eor_set == ras_clr));
endmodule

// File: tb/dma_req_mapper_test.sv
`timescale 1ns/1ps
module dma_req_mapper_test;
  localparam int NR = 75;
  localparam int NC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [15:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NR-1:0] req_in = '0;
  logic [NC-1:0] chan_active, ras_set, ras_clr, eor_set;
  logic          map_err;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_req_mapper #(.NUM_REQ(NR), .NUM_CH(NC)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_in(req_in),
    .chan_active(chan_active), .ras_set(ras_set), .ras_clr(ras_clr),
    .eor_set(eor_set), .map_err(map_err)
  );

  // ---------------- reference model ----------------
  int            m_map [NR];
  logic [NR-1:0] m_hist [$];
  logic [NC-1:0] m_act, m_rise, m_fall;
  bit            m_err;

  // Bench's own view of the address map: -1 means no map slot.
  function automatic int slot_of(int a);
    if (a % 4 != 0) return -1;
    if (a >= 256 && a <= 256 + 63 * 4) return (a - 256) / 4;
    if (a >= 4352 && a <= 4352 + (NR - 65) * 4) return 64 + (a - 4352) / 4;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NR; r++) m_map[r] = 0;
      m_hist.delete();
      m_act = '0; m_rise = '0; m_fall = '0; m_err = 0;
    end else begin
      logic [NC-1:0] nxt;
      logic [NR-1:0] old_req;
      int s;
      nxt = '0;
      old_req = (m_hist.size() >= 2) ? m_hist[1] : '0;
      for (int r = 0; r < NR; r++) begin
        if ((m_map[r] & 128) != 0 && (m_map[r] & 31) < NC && old_req[r])
          nxt[m_map[r] & 31] = 1'b1;
      end
      m_rise = nxt & ~m_act;
      m_fall = m_act & ~nxt;
      m_act  = nxt;
      m_hist.push_front(req_in);
      while (m_hist.size() > 2) void'(m_hist.pop_back());
      if (reg_we) begin
        s = slot_of(int'(reg_addr));
        if (s >= 0) begin
          m_map[s] = int'(reg_wdata[7:0]);
          if (reg_wdata[7] && int'(reg_wdata[4:0]) >= NC) m_err = 1;
        end
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Compare outputs with the model on every cycle, away from the edge.
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R5 chan_active", 64'(chan_active), 64'(m_act));
      chk("R6 ras_set", 64'(ras_set), 64'(m_rise));
      chk("R7 eor_set", 64'(eor_set), 64'(m_fall));
      chk("R7 ras_clr", 64'(ras_clr), 64'(m_fall));
      chk("R9 map_err", 64'(map_err), 64'(m_err));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 16'(a); reg_wdata = 32'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk);
    reg_addr = 16'(a);
    #1;
    chk(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int r, int len);
    @(negedge clk); req_in[r] = 1'b1;
    idle(len);
    req_in[r] = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- sequence ----------------
  initial begin
    logic [31:0] lfsr;
    idle(3);
    // R10: reset state
    chk("R10 chan_active", 64'(chan_active), 64'd0);
    chk("R10 events", 64'(ras_set | eor_set | ras_clr), 64'd0);
    chk("R10 map_err", 64'(map_err), 64'd0);
    rst_n = 1'b1;
    cmp_on = 1;
    rd(32'h100, 0, "R10 map0 reads zero");
    rd(32'h1128, 0, "R10 map74 reads zero");

    // R1 low window, R2 high window
    wr(32'h10C, 32'hFFFF_FF82);          // request 3 -> channel 2
    rd(32'h10C, 32'h82, "R1 readback req3");
    wr(32'h1118, 32'h85);                // request 70 -> channel 5
    rd(32'h1118, 32'h85, "R2 readback req70");
    rd(32'h118, 0, "R2 req6 not aliased by req70");
    wr(32'h200, 32'h81);
    rd(32'h200, 0, "R2 gap address stores nothing");
    rd(32'h1FC, 0, "R1 req63 untouched");

    // R3 status words
    wr(32'hE4, 32'hFF);
    rd(32'hE4, 0, "R3 status reads zero");
    rd(32'hE0, 0, "R3 status reads zero");
    rd(32'hE8, 0, "R3 status reads zero");
    rd(32'h10C, 32'h82, "R3 map unchanged after status write");

    // R5/R6/R7: single request on channel 2
    pulse(3, 6);
    idle(4);
    chk("R7 channel 2 idle after fall", 64'(chan_active), 64'd0);
    pulse(70, 2);
    idle(4);

    // R4: invalid entry and out-of-range entry do nothing
    wr(32'h12C, 32'h02);                 // request 11, valid bit clear
    pulse(11, 5);
    idle(2);
    chk("R4 invalid map ignored", 64'(chan_active | ras_set), 64'd0);
    pulse(10, 5);                        // request 10 never mapped
    idle(2);
    chk("R4 unmapped request ignored", 64'(chan_active | ras_set), 64'd0);

    // R9: in-range write keeps flag low, out-of-range raises it
    wr(32'h14C, 32'h8F);                 // request 19 -> channel 15
    chk("R9 in-range write no error", 64'(map_err), 64'd0);
    wr(32'h150, 32'h9F);                 // request 20 -> channel 31 (not built)
    idle(1);
    chk("R9 out-of-range write sets error", 64'(map_err), 64'd1);
    pulse(20, 5);
    idle(2);
    chk("R4 out-of-range channel ignored", 64'(chan_active), 64'd0);
    wr(32'h150, 32'h00);
    chk("R9 error stays set", 64'(map_err), 64'd1);

    // R8: two requests share channel 2
    wr(32'h110, 32'h82);                 // request 4 -> channel 2
    @(negedge clk); req_in[3] = 1'b1;
    idle(5);
    req_in[4] = 1'b1;
    idle(5);
    req_in[3] = 1'b0;
    idle(3);
    chk("R8 channel held by second request", 64'(chan_active[2]), 64'd1);
    chk("R8 no event on overlap", 64'(ras_set[2] | eor_set[2]), 64'd0);
    req_in[4] = 1'b0;
    idle(5);

    // R5: pseudo-random traffic across both windows
    wr(32'h100, 32'h80);                 // req 0  -> ch 0
    wr(32'h1FC, 32'h8F);                 // req 63 -> ch 15
    wr(32'h1100, 32'h80);                // req 64 -> ch 0
    wr(32'h1128, 32'h8F);                // req 74 -> ch 15
    wr(32'h1104, 32'h87);                // req 65 -> ch 7
    wr(32'h124, 32'h87);                 // req 9  -> ch 7
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (i % 3 == 0) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        req_in = {lfsr[10:0], lfsr, lfsr[31:0] ^ {lfsr[15:0], lfsr[31:16]}};
      end
    end
    @(negedge clk); req_in = '0;
    idle(6);
    chk("R5 all channels idle at end", 64'(chan_active), 64'd0);

    done = 1;
    cmp_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule